// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the low-order address bits that walk a synchronous burst memory through the beats of one burst. When a burst opens, it captures a starting address taken from the external bus. Each later cycle either steps to the next beat or, when no advance is requested, keeps the current address so the burst is paused. The upper address bits are kept elsewhere and do not pass through this block.

Two beat orders are available. The order is selected by a mode input and captured when a burst opens. In the linear order each beat adds one to the start address, and the sum wraps inside the aligned block of 2^ADDR_W addresses. In the interleaved order the address is the start address XORed with a beat index that counts up from zero. In both orders the sequence returns to the start address after the last beat of the block if advance is still held. The output is registered, so the address for a cycle's command appears one clock after that command.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset drives `burst_addr` to zero on the next rising clock edge. It also clears the captured start address and the beat index, and selects the linear order.
- R2: When `load` is high at a rising edge, `burst_addr` shows the value of `load_addr` from that edge on the following cycle.
- R3: When `load` and `adv` are both high at the same edge, the load wins: the output equals `load_addr` and the beat index restarts at zero.
- R4: When `load` and `adv` are both low at an edge, `burst_addr` keeps its value.
- R5: With the linear order captured (`mode` = 0 at the load), the output after k advances is (start + k) mod 2^ADDR_W.
- R6: With the interleaved order captured (`mode` = 1 at the load), the output after k advances is start XOR (k mod 2^ADDR_W).
- R7: After 2^ADDR_W advances with no load in between, the output is the start address again, and the same sequence repeats.
- R8: `mode` is sampled only in a load cycle. A change of `mode` during a burst does not change the order of that burst.
- R9: `load_addr` is ignored in every cycle where `load` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Opens a burst at `load_addr` |
| load_addr | input | ADDR_W | Starting low address bits of the burst |
| adv | input | 1 | Steps to the next beat when high; when low, the beat is held |
| mode | input | 1 | Beat order captured at load: 0 linear, 1 interleaved |
| burst_addr | output | ADDR_W | Registered current burst address |

## Verification
The bench builds two instances side by side. One uses ADDR_W = 2, the four-beat burst of the target memory. The other uses ADDR_W = 3, which checks that wrapping and XOR ordering scale with the parameter rather than being fixed at two bits. Both instances receive the same stimulus. Every start address in both orders is swept across more than one full wrap, with pauses inserted. The sweep also covers the collision of load and advance, mode toggles in the middle of a burst, and changes to the address bus while no load is requested.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/bseq_beat_ctr.sv
// Beat index within a burst: cleared at load, stepped on advance.
module bseq_beat_ctr #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] beat_q,
  output logic [ADDR_W-1:0] beat_nxt
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_comb begin
    if (clear)     beat_nxt = '0;
    else if (step) beat_nxt = beat_q + ONE;
    else           beat_nxt = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_nxt;
  end
endmodule

// File: rtl/bseq_order_map.sv
// Maps start address and beat index to a burst address for the chosen order.
module bseq_order_map #(
  parameter int ADDR_W = 2
) (
  input  logic              [ADDR_W-1:0] start,
  input  logic              [ADDR_W-1:0] beat,
  input  bseq_pkg::order_e               order,
  output logic              [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] lin_addr;
  logic [ADDR_W-1:0] xor_addr;

  // Natural wrap of the ADDR_W-bit sum keeps the linear walk in its block.
  assign lin_addr = start + beat;

  genvar gi;
  generate
    for (gi = 0; gi < ADDR_W; gi++) begin : g_xor_bit
      assign xor_addr[gi] = start[gi] ^ beat[gi];
    end
  endgenerate

  assign addr = (order == bseq_pkg::ORD_XOR) ? xor_addr : lin_addr;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              adv,
  input  logic              mode,
  output logic [ADDR_W-1:0] burst_addr
);
  import bseq_pkg::*;

  logic [ADDR_W-1:0] start_q, start_nxt;
  order_e            order_q, order_nxt;
  logic [ADDR_W-1:0] beat_q, beat_nxt;
  logic [ADDR_W-1:0] addr_nxt;

  // A load overrides an advance issued in the same cycle.
  assign start_nxt = load ? load_addr : start_q;
  assign order_nxt = load ? order_e'(mode) : order_q;

  bseq_beat_ctr #(.ADDR_W(ADDR_W)) u_beat (
    .clk      (clk),
    .rst      (rst),
    .clear    (load),
    .step     (adv),
    .beat_q   (beat_q),
    .beat_nxt (beat_nxt)
  );

  bseq_order_map #(.ADDR_W(ADDR_W)) u_map (
    .start (start_nxt),
    .beat  (beat_nxt),
    .order (order_nxt),
    .addr  (addr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q    <= '0;
      order_q    <= ORD_LINEAR;
      burst_addr <= '0;
    end else begin
      start_q    <= start_nxt;
      order_q    <= order_nxt;
      burst_addr <= addr_nxt;
    end
  end
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic [ADDR_W-1:0] load_addr,
  input logic              adv,
  input logic              mode,
  input logic [ADDR_W-1:0] burst_addr
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic              rst_d;
  logic [ADDR_W-1:0] ck_start;
  logic              ck_mode;
  logic [ADDR_W-1:0] ck_cnt;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      ck_start <= '0;
      ck_mode  <= 1'b0;
      ck_cnt   <= '0;
    end else if (load) begin
      ck_start <= load_addr;
      ck_mode  <= mode;
      ck_cnt   <= '0;
    end else if (adv) begin
      ck_cnt   <= ck_cnt + ADDR_W'(1);
    end
  end

  // R1: output cleared after a reset edge
  always @(negedge clk) begin
    if (rst_d === 1'b1) begin
      p_reset_clear_r1: assert (burst_addr == '0);
    end
  end

  p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> burst_addr == $past(load_addr));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(burst_addr));

  p_linear_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && adv && !ck_mode) |=> burst_addr == ADDR_W'($past(burst_addr) + ADDR_W'(1)));

  p_xor_beat_r6: assert property (@(posedge clk) disable iff (rst)
    (!load && adv && ck_mode) |=> (burst_addr ^ ck_start) == ck_cnt);

  p_wrap_start_r7: assert property (@(posedge clk) disable iff (rst)
    (!load && adv && ck_cnt == LAST) |=> burst_addr == ck_start);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load       (load),
  .load_addr  (load_addr),
  .adv        (adv),
  .mode       (mode),
  .burst_addr (burst_addr)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int CLK_P   = 10;
  localparam int TIMEOUT = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [2:0] load_addr = '0;
  logic       adv = 1'b0;
  logic       mode = 1'b0;
  logic [1:0] q2;
  logic [2:0] q3;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int m_start = 0;
  int m_mode  = 0;
  int m_k     = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(2)) u_burst_addr_seq (
    .clk(clk), .rst(rst), .load(load), .load_addr(load_addr[1:0]),
    .adv(adv), .mode(mode), .burst_addr(q2)
  );

  burst_addr_seq #(.ADDR_W(3)) u_burst_addr_seq_w3 (
    .clk(clk), .rst(rst), .load(load), .load_addr(load_addr),
    .adv(adv), .mode(mode), .burst_addr(q3)
  );

  function automatic int expv(int w);
    int n = 1 << w;
    int s = m_start % n;
    int kk = m_k % n;
    return (m_mode != 0) ? (s ^ kk) : ((s + kk) % n);
  endfunction

  task automatic compare(input string req);
    int e2 = expv(2);
    int e3 = expv(3);
    checks += 2;
    if (int'(q2) != e2) begin
      errors++;
      $display("FAIL %s w=2 actual=%0d expected=%0d", req, q2, e2);
    end
    if (int'(q3) != e3) begin
      errors++;
      $display("FAIL %s w=3 actual=%0d expected=%0d", req, q3, e3);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample a quarter period later.
  task automatic cyc(input bit ld, input int a, input bit ad, input bit md, input string req);
    @(negedge clk);
    load = ld; load_addr = 3'(a); adv = ad; mode = md;
    if (ld) begin m_start = a; m_mode = md; m_k = 0; end
    else if (ad) m_k++;
    @(posedge clk);
    #(CLK_P/4);
    compare(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; load = 1'b0; adv = 1'b1;
    m_start = 0; m_mode = 0; m_k = 0;
    @(posedge clk);
    #(CLK_P/4);
    compare("R1");
    @(negedge clk);
    rst = 1'b0; adv = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    do_reset();

    // R5 / R6 / R7: every start in both orders, past a full wrap, with a pause.
    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 8; s++) begin
        cyc(1'b1, s, 1'b0, md[0], "R2");
        for (int k = 1; k <= 10; k++) begin
          if (k == 3) cyc(1'b0, (s + 5) % 8, 1'b0, md[0], "R4");
          cyc(1'b0, s, 1'b1, md[0], (k >= 4) ? "R7" : ((md != 0) ? "R6" : "R5"));
        end
      end
    end

    // R3: load collides with advance
    cyc(1'b1, 5, 1'b0, 1'b1, "R2");
    cyc(1'b0, 5, 1'b1, 1'b1, "R6");
    cyc(1'b1, 2, 1'b1, 1'b1, "R3");
    cyc(1'b0, 2, 1'b1, 1'b1, "R3");
    cyc(1'b1, 6, 1'b1, 1'b0, "R3");

    // R8: mode toggles mid-burst
    cyc(1'b1, 1, 1'b0, 1'b0, "R2");
    for (int k = 0; k < 5; k++) cyc(1'b0, 1, 1'b1, k[0] ? 1'b0 : 1'b1, "R8");
    cyc(1'b1, 3, 1'b0, 1'b1, "R2");
    for (int k = 0; k < 5; k++) cyc(1'b0, 3, 1'b1, k[0] ? 1'b1 : 1'b0, "R8");

    // R9: address bus moves while no load
    cyc(1'b1, 4, 1'b0, 1'b0, "R2");
    for (int a = 0; a < 8; a++) cyc(1'b0, a, a[0], 1'b0, "R9");

    // R1: reset in the middle of a burst
    cyc(1'b1, 7, 1'b0, 1'b1, "R2");
    cyc(1'b0, 7, 1'b1, 1'b1, "R6");
    do_reset();
    cyc(1'b0, 6, 1'b1, 1'b1, "R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (TIMEOUT) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule